// File: doc/BRIEF.md
# Audio Codec Controller Register Front End

This block sits between a 32-bit processor bus and the sample and command ports of an AC97-style audio codec link. Software writes 16-bit playback samples into one FIFO and reads 16-bit record samples out of another. It watches both FIFOs through a single status word. It reaches the codec's own control registers through an address/command register, a write-data register and a read-data register, with a completion flag for each access. Samples are signed 16-bit with two interleaved channels, so software moves one bus word per channel sample. Only the low 16 bits of a bus word carry sample or codec data.

The codec side sees plain handshakes. It pulses `play_pop` to take the next playback sample and `rec_push` to deliver a captured one. It sees a codec command as a request level with address, direction and write data, and it answers with a one-cycle acknowledge that carries read data. The block also offers two interrupt levels, one per FIFO. Bus reads have one cycle of latency: `bus_rdata` is valid in the cycle after `bus_rd` is sampled. Bus writes take effect at the edge where `bus_wr` is sampled.

Top module: `audio_ctrl_regs`

## Requirements
- R1: After reset the status word reads 0x1A with `codec_ready` low: play half (bit 1), record empty (bit 3) and access done (bit 4) are set. `cmd_req` and `irq_rec` are low, and `irq_play` is high.
- R2: The playback FIFO holds 32 samples and returns them in write order, one per `play_pop`, on `play_sample` in the cycle after the pop. Only `bus_wdata[15:0]` is stored. A write to offset 0x00 while the FIFO holds 32 samples is dropped.
- R3: A read of offset 0x04 returns the oldest record sample in bits 15:0 with bits 31:16 zero. When the record FIFO is empty the read returns zero and changes nothing.
- R4: Status (offset 0x08) bits are: 0 play full, 1 play half, 2 record full, 3 record empty, 4 codec access done, 5 the `codec_ready` input, 6 play underrun, 7 record overrun. All other bits read zero.
- R5: Play half (status bit 1, and `irq_play`) is set exactly while the playback FIFO holds 16 or fewer samples.
- R6: A `play_pop` on an empty playback FIFO gives `play_sample` = 0 and sets underrun (bit 6). Underrun stays set until a playback FIFO reset.
- R7: A `rec_push` into a full record FIFO drops the sample and sets overrun (bit 7). Overrun stays set until a record FIFO reset.
- R8: Writing offset 0x0C with bit 0 set empties the playback FIFO and clears underrun. Bit 1 does the same for the record FIFO and overrun. Either bit alone leaves the other FIFO untouched.
- R9: Writing offset 0x10 starts a codec command: bits 6:0 become `cmd_addr`, and bit 7 becomes `cmd_rnw` (1 = read, 0 = write of the value last written to offset 0x18, shown on `cmd_wdata`). `cmd_req` rises and the done bit clears in the next cycle.
- R10: A `cmd_ack` while `cmd_req` is high drops `cmd_req` and sets done. For a read it latches `cmd_rdata`, which a read of offset 0x14 then returns.
- R11: `irq_rec` is high exactly while the record FIFO is not empty.
- R12: When a FIFO's push and pop fall in the same cycle, a non-empty FIFO serves the pop. The push is accepted even when the FIFO is full, because the pop frees a slot. A FIFO that was empty returns zero for the pop and stores the pushed sample.
- R13: Offset 0x10 reads back the last command byte, and offset 0x18 reads back the codec write data. Offsets 0x00, 0x0C and any unmapped offset read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| play_pop | input | 1 | Codec side takes one playback sample |
| play_sample | output | 16 | Sample delivered by the last pop |
| rec_push | input | 1 | Codec side delivers one record sample |
| rec_sample | input | 16 | Record sample value |
| codec_ready | input | 1 | Codec ready indication, reported in status |
| cmd_req | output | 1 | Codec command pending |
| cmd_rnw | output | 1 | Pending command is a read |
| cmd_addr | output | 7 | Codec register address |
| cmd_wdata | output | 16 | Codec write data |
| cmd_ack | input | 1 | Codec completes the pending command |
| cmd_rdata | input | 16 | Codec read data, valid with `cmd_ack` |
| irq_play | output | 1 | Playback FIFO at or below half |
| irq_rec | output | 1 | Record FIFO has data |

## Verification
Each FIFO can see its bus-side access and its codec-side access in the same cycle. The overlap matters most at the two boundaries: a bus write and a `play_pop` on a full playback FIFO, a `play_pop` and a bus write on an empty one, and a `rec_push` and a bus read on an empty record FIFO. The bench drives both strobes in one cycle for each case. It judges the result by the returned sample, the sticky flags and the exact sequence of later pops compared with a queue model.

// File: rtl/acr_pkg.sv
package acr_pkg;

  localparam logic [4:0] OFF_PLAY = 5'h00;
  localparam logic [4:0] OFF_REC  = 5'h04;
  localparam logic [4:0] OFF_STAT = 5'h08;
  localparam logic [4:0] OFF_FRST = 5'h0C;
  localparam logic [4:0] OFF_CMD  = 5'h10;
  localparam logic [4:0] OFF_CRD  = 5'h14;
  localparam logic [4:0] OFF_CWD  = 5'h18;

  // status word, bit 7 down to bit 0
  typedef struct packed {
    logic rec_ovr;
    logic play_und;
    logic codec_rdy;
    logic acc_done;
    logic rec_empty;
    logic rec_full;
    logic play_half;
    logic play_full;
  } status_t;

endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty,
  output logic                       push_drop,
  output logic                       pop_miss
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          pop_ok, push_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_CNT);
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);
  assign push_drop = push && !flush && !push_ok;
  assign pop_miss  = pop && !flush && empty;
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (pop) begin
      dout <= pop_ok ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R2
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT);

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (cnt == FULL_CNT));

  // R12
  both_sides_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty && push && pop && !flush) |=> $stable(cnt));

endmodule

// File: rtl/codec_port.sv
module codec_port #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [AW:0]   cmd_byte,
  input  logic          wd_we,
  input  logic [DW-1:0] wd_in,
  input  logic          ack,
  input  logic [DW-1:0] ack_data,
  output logic          req,
  output logic          rnw,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      rnw   <= 1'b0;
      addr  <= '0;
      rdata <= '0;
      done  <= 1'b1;
    end else if (cmd_we) begin
      addr <= cmd_byte[AW-1:0];
      rnw  <= cmd_byte[AW];
      req  <= 1'b1;
      done <= 1'b0;
    end else if (ack && req) begin
      req  <= 1'b0;
      done <= 1'b1;
      if (rnw) rdata <= ack_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        wdata <= '0;
    else if (wd_we) wdata <= wd_in;
  end

  // R9
  cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_we |=> (req && !done));

  // R10
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req && !cmd_we) |=> (done && !req));

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> !done);

endmodule

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs #(
  parameter int SAMPLE_W   = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int CREG_AW    = 7,
  parameter int BUS_AW     = 5,
  parameter int BUS_W      = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                play_pop,
  output logic [SAMPLE_W-1:0] play_sample,
  input  logic                rec_push,
  input  logic [SAMPLE_W-1:0] rec_sample,
  input  logic                codec_ready,
  output logic                cmd_req,
  output logic                cmd_rnw,
  output logic [CREG_AW-1:0]  cmd_addr,
  output logic [SAMPLE_W-1:0] cmd_wdata,
  input  logic                cmd_ack,
  input  logic [SAMPLE_W-1:0] cmd_rdata,
  output logic                irq_play,
  output logic                irq_rec
);
  import acr_pkg::*;

  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [CW-1:0] HALF_CNT = CW'(FIFO_DEPTH / 2);

  logic [4:0] off;
  assign off = 5'(bus_addr);

  logic wr_play, wr_frst, wr_cmd, wr_cwd, rd_rec;
  assign wr_play = bus_wr && (off == OFF_PLAY);
  assign wr_frst = bus_wr && (off == OFF_FRST);
  assign wr_cmd  = bus_wr && (off == OFF_CMD);
  assign wr_cwd  = bus_wr && (off == OFF_CWD);
  assign rd_rec  = bus_rd && (off == OFF_REC);

  logic play_flush, rec_flush;
  assign play_flush = wr_frst && bus_wdata[0];
  assign rec_flush  = wr_frst && bus_wdata[1];

  logic [CW-1:0]       p_cnt, r_cnt;
  logic                p_full, p_empty, p_drop, p_miss;
  logic                r_full, r_empty, r_drop, r_miss;
  logic [SAMPLE_W-1:0] r_dout;

  sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_play (
    .clk(clk), .rst(rst), .flush(play_flush),
    .push(wr_play), .din(bus_wdata[SAMPLE_W-1:0]),
    .pop(play_pop), .dout(play_sample),
    .count(p_cnt), .full(p_full), .empty(p_empty),
    .push_drop(p_drop), .pop_miss(p_miss)
  );

  sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rec (
    .clk(clk), .rst(rst), .flush(rec_flush),
    .push(rec_push), .din(rec_sample),
    .pop(rd_rec), .dout(r_dout),
    .count(r_cnt), .full(r_full), .empty(r_empty),
    .push_drop(r_drop), .pop_miss(r_miss)
  );

  logic acc_done;
  logic [CREG_AW:0] cmd_byte_q;

  codec_port #(.AW(CREG_AW), .DW(SAMPLE_W)) u_codec (
    .clk(clk), .rst(rst),
    .cmd_we(wr_cmd), .cmd_byte(bus_wdata[CREG_AW:0]),
    .wd_we(wr_cwd), .wd_in(bus_wdata[SAMPLE_W-1:0]),
    .ack(cmd_ack), .ack_data(cmd_rdata),
    .req(cmd_req), .rnw(cmd_rnw), .addr(cmd_addr),
    .wdata(cmd_wdata), .rdata(rd_codec), .done(acc_done)
  );

  logic [SAMPLE_W-1:0] rd_codec;

  always_ff @(posedge clk) begin
    if (rst)         cmd_byte_q <= '0;
    else if (wr_cmd) cmd_byte_q <= bus_wdata[CREG_AW:0];
  end

  // sticky error flags, cleared only by the matching FIFO reset
  logic und_q, ovr_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      und_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (play_flush)  und_q <= 1'b0;
      else if (p_miss) und_q <= 1'b1;
      if (rec_flush)   ovr_q <= 1'b0;
      else if (r_drop) ovr_q <= 1'b1;
    end
  end

  status_t stat;
  always_comb begin
    stat.play_full = p_full;
    stat.play_half = (p_cnt <= HALF_CNT);
    stat.rec_full  = r_full;
    stat.rec_empty = r_empty;
    stat.acc_done  = acc_done;
    stat.codec_rdy = codec_ready;
    stat.play_und  = und_q;
    stat.rec_ovr   = ovr_q;
  end

  assign irq_play = stat.play_half;
  assign irq_rec  = !r_empty;

  // read path: snapshot at the read edge; record data comes from the FIFO output register
  logic [BUS_W-1:0] rd_hold;
  logic             rd_from_rec;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hold     <= '0;
      rd_from_rec <= 1'b0;
    end else if (bus_rd) begin
      rd_from_rec <= (off == OFF_REC);
      case (off)
        OFF_STAT: rd_hold <= BUS_W'(stat);
        OFF_CMD:  rd_hold <= BUS_W'(cmd_byte_q);
        OFF_CRD:  rd_hold <= BUS_W'(rd_codec);
        OFF_CWD:  rd_hold <= BUS_W'(cmd_wdata);
        default:  rd_hold <= '0;
      endcase
    end
  end

  assign bus_rdata = rd_from_rec ? BUS_W'(r_dout) : rd_hold;

  // R6
  und_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (und_q && !play_flush) |=> und_q);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !rec_flush) |=> ovr_q);

  // R8
  flush_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (play_flush && !rec_flush && !rec_push && !rd_rec) |=> $stable(r_cnt));

  // R6
  und_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (play_pop && p_empty && !play_flush) |=> (und_q && play_sample == '0));

endmodule

// File: tb/test_audio_ctrl_regs.sv
module test_audio_ctrl_regs;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        play_pop;
  logic [15:0] play_sample;
  logic        rec_push;
  logic [15:0] rec_sample;
  logic        codec_ready;
  logic        cmd_req, cmd_rnw;
  logic [6:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic        cmd_ack;
  logic [15:0] cmd_rdata;
  logic        irq_play, irq_rec;

  always #4 clk = ~clk;

  audio_ctrl_regs i_audio_ctrl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .play_pop(play_pop),
    .play_sample(play_sample), .rec_push(rec_push), .rec_sample(rec_sample),
    .codec_ready(codec_ready), .cmd_req(cmd_req), .cmd_rnw(cmd_rnw),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack),
    .cmd_rdata(cmd_rdata), .irq_play(irq_play), .irq_rec(irq_rec)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] pq[$];
  logic [15:0] rq[$];
  bit m_und, m_ovr, m_done;

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0] = (pq.size() == 32);
    s[1] = (pq.size() <= 16);
    s[2] = (rq.size() == 32);
    s[3] = (rq.size() == 0);
    s[4] = m_done;
    s[5] = codec_ready;
    s[6] = m_und;
    s[7] = m_ovr;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic bwrite(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a == 5'h00 && pq.size() < 32) pq.push_back(d[15:0]);
    if (a == 5'h0C && d[0]) begin pq.delete(); m_und = 0; end
    if (a == 5'h0C && d[1]) begin rq.delete(); m_ovr = 0; end
    if (a == 5'h10) m_done = 0;
  endtask

  task automatic bread(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic chk_status(input string req);
    logic [31:0] e, d;
    e = exp_status();
    bread(5'h08, d);
    check(req, d, e);
  endtask

  task automatic rec_read(input string req);
    logic [31:0] d, e;
    e = (rq.size() > 0) ? {16'h0, rq.pop_front()} : 32'h0;
    bread(5'h04, d);
    check(req, d, e);
  endtask

  task automatic cpop(input string req);
    logic [15:0] e;
    if (pq.size() > 0) e = pq.pop_front();
    else begin e = 16'h0; m_und = 1; end
    play_pop = 1'b1;
    @(negedge clk);
    play_pop = 1'b0;
    check(req, {16'h0, play_sample}, {16'h0, e});
  endtask

  task automatic cpush(input logic [15:0] v);
    if (rq.size() < 32) rq.push_back(v); else m_ovr = 1;
    rec_push = 1'b1; rec_sample = v;
    @(negedge clk);
    rec_push = 1'b0;
  endtask

  task automatic cack(input logic [15:0] v);
    cmd_ack = 1'b1; cmd_rdata = v;
    @(negedge clk);
    cmd_ack = 1'b0;
    m_done = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst = 1'b1; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    play_pop = 0; rec_push = 0; rec_sample = '0; codec_ready = 0;
    cmd_ack = 0; cmd_rdata = '0;
    m_und = 0; m_ovr = 0; m_done = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_play", {31'h0, irq_play}, 32'h1);
    check("R1 irq_rec", {31'h0, irq_rec}, 32'h0);
    check("R1 cmd_req", {31'h0, cmd_req}, 32'h0);
    bread(5'h08, d);
    check("R1 status", d, 32'h0000_001A);
    codec_ready = 1'b1;
    chk_status("R4 codec ready bit");

    // R5 half threshold, R2 fill
    for (int i = 0; i < 16; i++) bwrite(5'h00, {16'hDEAD, 16'(i * 257 + 3)});
    chk_status("R5 16 entries half");
    check("R5 irq_play at 16", {31'h0, irq_play}, 32'h1);
    bwrite(5'h00, 32'h0000_1111);
    chk_status("R5 17 entries not half");
    check("R5 irq_play at 17", {31'h0, irq_play}, 32'h0);
    for (int i = 17; i < 32; i++) bwrite(5'h00, 32'($urandom));
    chk_status("R2 full");
    bwrite(5'h00, 32'h0000_9999);
    chk_status("R2 write when full dropped");
    for (int i = 0; i < 32; i++) cpop("R2 playback order");
    cpop("R6 pop empty returns zero");
    chk_status("R6 underrun set");
    cpop("R6 second empty pop");
    chk_status("R6 underrun sticky");

    // R8 independence: record holds data while playback is reset
    cpush(16'hA5A5); cpush(16'h5A5A);
    bwrite(5'h0C, 32'h1);
    chk_status("R8 play reset clears underrun only");
    check("R11 irq_rec with data", {31'h0, irq_rec}, 32'h1);
    rec_read("R8 record kept across play reset");
    rec_read("R8 record kept second");
    check("R11 irq_rec empty", {31'h0, irq_rec}, 32'h0);
    rec_read("R3 empty read zero");
    chk_status("R3 empty read no effect");

    // R7 overrun
    for (int i = 0; i < 33; i++) cpush(16'(i * 31 + 7));
    chk_status("R7 overrun and full");
    bwrite(5'h00, 32'h0000_4321);
    bwrite(5'h0C, 32'h2);
    chk_status("R8 rec reset keeps playback");
    cpop("R8 playback kept across rec reset");
    for (int i = 0; i < 32; i++) cpush(16'(i ^ 16'h0F0F));
    for (int i = 0; i < 32; i++) rec_read("R3 record order");

    // R9 / R10 codec commands
    bwrite(5'h18, 32'hFFFF_1234);
    bwrite(5'h10, 32'h0000_0005);
    check("R9 req", {31'h0, cmd_req}, 32'h1);
    check("R9 rnw write", {31'h0, cmd_rnw}, 32'h0);
    check("R9 addr", {25'h0, cmd_addr}, 32'h5);
    check("R9 wdata", {16'h0, cmd_wdata}, 32'h1234);
    chk_status("R9 done cleared");
    cack(16'h7777);
    check("R10 req dropped", {31'h0, cmd_req}, 32'h0);
    chk_status("R10 done set");
    bwrite(5'h10, 32'h0000_00A2);
    check("R9 rnw read", {31'h0, cmd_rnw}, 32'h1);
    check("R9 read addr", {25'h0, cmd_addr}, 32'h22);
    cack(16'hBEEF);
    bread(5'h14, d);
    check("R10 read data", d, 32'h0000_BEEF);
    bread(5'h10, d);
    check("R13 cmd readback", d, 32'h0000_00A2);
    bread(5'h18, d);
    check("R13 wdata readback", d, 32'h0000_1234);
    bread(5'h00, d);
    check("R13 play offset reads zero", d, 32'h0);
    bread(5'h1C, d);
    check("R13 unmapped reads zero", d, 32'h0);

    // R12 same-cycle push and pop
    bwrite(5'h0C, 32'h3);
    for (int i = 0; i < 32; i++) bwrite(5'h00, 32'(i + 100));
    bus_addr = 5'h00; bus_wdata = 32'h0000_CAFE; bus_wr = 1; play_pop = 1;
    @(negedge clk);
    bus_wr = 0; play_pop = 0;
    check("R12 full pop data", {16'h0, play_sample}, {16'h0, pq.pop_front()});
    pq.push_back(16'hCAFE);
    chk_status("R12 full write accepted");
    for (int i = 0; i < 32; i++) cpop("R12 order after full overlap");
    bus_addr = 5'h00; bus_wdata = 32'h0000_0BAD; bus_wr = 1; play_pop = 1;
    @(negedge clk);
    bus_wr = 0; play_pop = 0;
    check("R12 empty pop zero", {16'h0, play_sample}, 32'h0);
    m_und = 1; pq.push_back(16'h0BAD);
    chk_status("R12 empty overlap stores and underruns");
    cpop("R12 stored sample");
    bus_addr = 5'h04; bus_rd = 1; rec_push = 1; rec_sample = 16'h3C3C;
    @(negedge clk);
    bus_rd = 0; rec_push = 0;
    check("R12 rec empty read zero", bus_rdata, 32'h0);
    rq.push_back(16'h3C3C);
    rec_read("R12 rec sample stored");

    // random mix against the queue model
    for (int k = 0; k < 600; k++) begin
      case ($urandom % 7)
        0, 1: bwrite(5'h00, $urandom);
        2:    cpop("R2 random pop");
        3:    cpush(16'($urandom));
        4:    rec_read("R3 random read");
        5:    chk_status("R4 random status");
        default: if ($urandom % 8 == 0) bwrite(5'h0C, 32'($urandom % 4));
      endcase
      if (irq_rec !== (rq.size() != 0)) check("R11 random irq_rec", {31'h0, irq_rec}, {31'h0, rq.size() != 0});
      if (irq_play !== (pq.size() <= 16)) check("R5 random irq_play", {31'h0, irq_play}, {31'h0, pq.size() <= 16});
    end
    chk_status("R4 final status");
    report();
  end

endmodule